// File: doc/BRIEF.md
# Display Window Update Setup Sequencer

This block drives the command side of a parallel display bus master. When told to bring up the link, it reads two identification registers from the attached display controller. From them it decides which controller variant is present, the silicon revision and the strap settings. Bring-up stops with an error code when the identification value matches no known variant.

Before each frame update, software presents a window origin and size. The block accepts only a window that covers the whole screen. For an accepted window it computes the end coordinates and narrows the bus to 8 data lines. It then sends the window register command followed by an 18-byte data burst, widens the bus back to 16 lines for the pixel stream that follows, and pulses a done flag. The last byte of the burst is a data-source code that depends on the variant found at bring-up.

The bus master sees one transfer at a time through a valid/ready pair. Each transfer carries a kind (command, data write or data read) and a byte. Read data is taken in the cycle the read transfer is accepted.

Top module: `win_setup_seq`

## Requirements
- R1: After reset the bus is in 16-line mode (`bm_narrow`=0), no transfer is offered, `ctl_kind` is 0 (not probed), and `probe_done`, `upd_done`, `upd_bad` and `upd_busy_rej` are low.
- R2: A `probe_go` pulse while idle produces exactly four transfers in this order: command 0x00, one data read, command 0x02, one data read. `probe_done` then pulses for one cycle. Bus kind codes are 0 for command, 1 for data write and 2 for data read.
- R3: With the first read byte called the identity value, `ctl_kind` becomes 1 when (identity & 0xFC) = 0xA4, 2 when it equals 0x9C, and 3 otherwise (bring-up aborted). It is valid from the cycle `probe_done` is high.
- R4: Together with `probe_done`, `sil_rev` shows bits 1:0 of the identity value and `strap` shows bits 2:0 of the second read byte.
- R5: An update request is accepted only when x=0, y=0, w=H_RES and h=V_RES (800 and 480 by default). Any other region raises `upd_bad` for one cycle, in the cycle after the request, and causes no bus traffic.
- R6: An accepted update sends command 0x6C and then 18 data writes. Bytes 0..7 are x, y, x+w-1 and y+h-1, each 16 bits with the low byte first. Bytes 8..15 repeat bytes 0..7. Byte 16 is 0x01.
- R7: Byte 17 of the burst is 0x00 when `ctl_kind` is 1 or 2, and 0x01 when it is 0 or 3.
- R8: `bm_narrow` is high from the cycle after an update is accepted through the last burst byte, and low at all other times, including during probe reads.
- R9: `upd_done` is a single-cycle pulse. It comes one cycle after `bm_narrow` has returned low.
- R10: An update request while a probe or an update is running is refused. `upd_busy_rej` pulses in the next cycle and no extra traffic follows. A request in the same cycle as `probe_go` is refused the same way, because the probe takes priority.
- R11: While `bm_valid` is high and `bm_ready` is low, `bm_kind` and `bm_byte` stay unchanged and `bm_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_go | input | 1 | Start controller identification |
| probe_done | output | 1 | Identification finished (pulse) |
| ctl_kind | output | 2 | 0 none, 1 variant A, 2 variant B, 3 unsupported |
| sil_rev | output | 2 | Silicon revision from identity bits 1:0 |
| strap | output | 3 | Strap settings from configuration bits 2:0 |
| upd_req | input | 1 | Update request (pulse) |
| upd_x | input | COORD_W | Window origin x |
| upd_y | input | COORD_W | Window origin y |
| upd_w | input | COORD_W | Window width |
| upd_h | input | COORD_W | Window height |
| upd_bad | output | 1 | Region refused (pulse) |
| upd_busy_rej | output | 1 | Request refused while busy (pulse) |
| upd_done | output | 1 | Burst sent and bus widened (pulse) |
| bm_valid | output | 1 | Transfer offered to the bus master |
| bm_ready | input | 1 | Bus master takes the transfer |
| bm_kind | output | 2 | 0 command, 1 data write, 2 data read |
| bm_byte | output | 8 | Command or write byte |
| bm_rdata | input | 8 | Read byte, taken when a read is accepted |
| bm_narrow | output | 1 | 1 selects 8 data lines, 0 selects 16 |

## Verification
The hardest case to reach is a second update request that arrives while a burst is stalled mid-stream, together with a check that the refused request leaves no trace on the bus afterwards. The bench's bus model drops `bm_ready` on a pseudo-random pattern, so bursts stretch over many cycles. It then injects the second request a few cycles after acceptance and counts every logged transfer until well after the done pulse. It also probes the full sweep of 256 identity values, so every mask outcome is seen. It sweeps a grid of window sizes around the screen size, in which exactly one point is accepted.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
   typedef enum logic [1:0] {
      BK_CMD = 2'd0,
      BK_WR  = 2'd1,
      BK_RD  = 2'd2
   } bus_kind_e;

   typedef enum logic [1:0] {
      CK_NONE = 2'd0,
      CK_A    = 2'd1,
      CK_B    = 2'd2,
      CK_BAD  = 2'd3
   } ctl_kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PCMD,
      S_PRD,
      S_UCMD,
      S_UDAT,
      S_FIN
   } seq_state_e;

   localparam logic [7:0] REG_IDENT  = 8'h00;
   localparam logic [7:0] REG_CONF   = 8'h02;
   localparam logic [7:0] REG_WINDOW = 8'h6C;
   localparam logic [7:0] FMT_RGB565 = 8'h01;
   localparam logic [7:0] SRC_KNOWN  = 8'h00;
   localparam logic [7:0] SRC_OTHER  = 8'h01;
   localparam logic [7:0] ID_MASK    = 8'hFC;
   localparam logic [7:0] ID_VAR_A   = 8'hA4;
   localparam logic [7:0] ID_VAR_B   = 8'h9C;
endpackage

// File: rtl/wsq_classify.sv
module wsq_classify
   import wsq_pkg::*;
#(
   parameter logic [7:0] MASK  = ID_MASK,
   parameter logic [7:0] VAR_A = ID_VAR_A,
   parameter logic [7:0] VAR_B = ID_VAR_B
) (
   input  logic [7:0] ident,
   output logic [1:0] kind
);
   logic [7:0] masked;

   assign masked = ident & MASK;

   always_comb begin
      if (masked == VAR_A)
         kind = CK_A;
      else if (masked == VAR_B)
         kind = CK_B;
      else
         kind = CK_BAD;
   end
endmodule

// File: rtl/wsq_window.sv
module wsq_window #(
   parameter int COORD_W = 16,
   parameter int H_RES   = 800,
   parameter int V_RES   = 480
) (
   input  logic [COORD_W-1:0] x,
   input  logic [COORD_W-1:0] y,
   input  logic [COORD_W-1:0] w,
   input  logic [COORD_W-1:0] h,
   output logic [COORD_W-1:0] x_end,
   output logic [COORD_W-1:0] y_end,
   output logic               full_screen
);
   localparam logic [COORD_W-1:0] ONE   = COORD_W'(1);
   localparam logic [COORD_W-1:0] HFULL = COORD_W'(H_RES);
   localparam logic [COORD_W-1:0] VFULL = COORD_W'(V_RES);

   assign x_end = x + w - ONE;
   assign y_end = y + h - ONE;

   assign full_screen = (x == '0) && (y == '0) && (w == HFULL) && (h == VFULL);
endmodule

// File: rtl/wsq_burst_mux.sv
module wsq_burst_mux
   import wsq_pkg::*;
#(
   parameter int COORD_W = 16,
   parameter int IW      = 5
) (
   input  logic [COORD_W-1:0] x,
   input  logic [COORD_W-1:0] y,
   input  logic [COORD_W-1:0] x_end,
   input  logic [COORD_W-1:0] y_end,
   input  logic [7:0]         src_code,
   input  logic [IW-1:0]      idx,
   output logic [7:0]         byte_out
);
   localparam int CB = COORD_W / 8;
   localparam int G  = 4 * CB;
   localparam int GW = (G > 1) ? $clog2(G) : 1;

   logic [COORD_W-1:0] crd [4];
   logic [7:0]         grp [G];
   logic [IW-1:0]      off;

   assign crd[0] = x;
   assign crd[1] = y;
   assign crd[2] = x_end;
   assign crd[3] = y_end;

   for (genvar c = 0; c < 4; c++) begin : g_coord
      for (genvar b = 0; b < CB; b++) begin : g_byte
         assign grp[c*CB + b] = crd[c][b*8 +: 8];
      end
   end

   assign off = (idx >= IW'(G)) ? idx - IW'(G) : idx;

   always_comb begin
      if (idx < IW'(2 * G))
         byte_out = grp[off[GW-1:0]];
      else if (idx == IW'(2 * G))
         byte_out = FMT_RGB565;
      else
         byte_out = src_code;
   end
endmodule

// File: rtl/win_setup_seq.sv
module win_setup_seq
   import wsq_pkg::*;
#(
   parameter int COORD_W = 16,
   parameter int H_RES   = 800,
   parameter int V_RES   = 480
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               probe_go,
   output logic               probe_done,
   output logic [1:0]         ctl_kind,
   output logic [1:0]         sil_rev,
   output logic [2:0]         strap,
   input  logic               upd_req,
   input  logic [COORD_W-1:0] upd_x,
   input  logic [COORD_W-1:0] upd_y,
   input  logic [COORD_W-1:0] upd_w,
   input  logic [COORD_W-1:0] upd_h,
   output logic               upd_bad,
   output logic               upd_busy_rej,
   output logic               upd_done,
   output logic               bm_valid,
   input  logic               bm_ready,
   output logic [1:0]         bm_kind,
   output logic [7:0]         bm_byte,
   input  logic [7:0]         bm_rdata,
   output logic               bm_narrow
);
   localparam int CB        = COORD_W / 8;
   localparam int BURST_LEN = 8 * CB + 2;
   localparam int IW        = $clog2(BURST_LEN);
   localparam logic [IW-1:0] LAST = IW'(BURST_LEN - 1);

   if (COORD_W < 8 || (COORD_W % 8) != 0) begin : g_bad_width
      $error("COORD_W must be a positive multiple of 8");
   end
   if (H_RES < 1 || H_RES >= (1 << COORD_W)) begin : g_bad_hres
      $error("H_RES must fit in COORD_W bits");
   end
   if (V_RES < 1 || V_RES >= (1 << COORD_W)) begin : g_bad_vres
      $error("V_RES must fit in COORD_W bits");
   end

   seq_state_e         st;
   logic               phase;
   logic [IW-1:0]      idx;
   logic [7:0]         ident_q;
   logic [1:0]         kind_q;
   logic [COORD_W-1:0] x_q, y_q, xe_q, ye_q;
   logic               narrow_q;

   logic [COORD_W-1:0] xe_c, ye_c;
   logic               full_c;
   logic [1:0]         kind_c;
   logic [7:0]         src_c;
   logic [7:0]         burst_byte;
   logic               xfer;
   logic               idle;

   wsq_window #(.COORD_W(COORD_W), .H_RES(H_RES), .V_RES(V_RES)) i_window (
      .x(upd_x), .y(upd_y), .w(upd_w), .h(upd_h),
      .x_end(xe_c), .y_end(ye_c), .full_screen(full_c)
   );

   wsq_classify i_classify (
      .ident(ident_q),
      .kind (kind_c)
   );

   assign src_c = (kind_q == CK_A || kind_q == CK_B) ? SRC_KNOWN : SRC_OTHER;

   wsq_burst_mux #(.COORD_W(COORD_W), .IW(IW)) i_mux (
      .x(x_q), .y(y_q), .x_end(xe_q), .y_end(ye_q),
      .src_code(src_c), .idx(idx), .byte_out(burst_byte)
   );

   assign idle = (st == S_IDLE);

   always_comb begin
      bm_valid = 1'b0;
      bm_kind  = BK_CMD;
      bm_byte  = 8'h00;
      unique case (st)
         S_PCMD: begin
            bm_valid = 1'b1;
            bm_byte  = phase ? REG_CONF : REG_IDENT;
         end
         S_PRD: begin
            bm_valid = 1'b1;
            bm_kind  = BK_RD;
         end
         S_UCMD: begin
            bm_valid = 1'b1;
            bm_byte  = REG_WINDOW;
         end
         S_UDAT: begin
            bm_valid = 1'b1;
            bm_kind  = BK_WR;
            bm_byte  = burst_byte;
         end
         default: ;
      endcase
   end

   assign xfer      = bm_valid && bm_ready;
   assign bm_narrow = narrow_q;
   assign ctl_kind  = kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= S_IDLE;
         phase        <= 1'b0;
         idx          <= '0;
         ident_q      <= 8'h00;
         kind_q       <= CK_NONE;
         sil_rev      <= 2'b00;
         strap        <= 3'b000;
         x_q          <= '0;
         y_q          <= '0;
         xe_q         <= '0;
         ye_q         <= '0;
         narrow_q     <= 1'b0;
         probe_done   <= 1'b0;
         upd_bad      <= 1'b0;
         upd_busy_rej <= 1'b0;
         upd_done     <= 1'b0;
      end else begin
         probe_done   <= 1'b0;
         upd_bad      <= 1'b0;
         upd_busy_rej <= 1'b0;
         upd_done     <= 1'b0;

         if (upd_req && (!idle || probe_go))
            upd_busy_rej <= 1'b1;

         unique case (st)
            S_IDLE: begin
               if (probe_go) begin
                  st    <= S_PCMD;
                  phase <= 1'b0;
               end else if (upd_req) begin
                  if (full_c) begin
                     x_q      <= upd_x;
                     y_q      <= upd_y;
                     xe_q     <= xe_c;
                     ye_q     <= ye_c;
                     narrow_q <= 1'b1;
                     st       <= S_UCMD;
                  end else begin
                     upd_bad <= 1'b1;
                  end
               end
            end
            S_PCMD: if (xfer) st <= S_PRD;
            S_PRD: begin
               if (xfer) begin
                  if (!phase) begin
                     ident_q <= bm_rdata;
                     phase   <= 1'b1;
                     st      <= S_PCMD;
                  end else begin
                     kind_q     <= kind_c;
                     sil_rev    <= ident_q[1:0];
                     strap      <= bm_rdata[2:0];
                     probe_done <= 1'b1;
                     st         <= S_IDLE;
                  end
               end
            end
            S_UCMD: begin
               if (xfer) begin
                  idx <= '0;
                  st  <= S_UDAT;
               end
            end
            S_UDAT: begin
               if (xfer) begin
                  if (idx == LAST) begin
                     narrow_q <= 1'b0;
                     st       <= S_FIN;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            S_FIN: begin
               upd_done <= 1'b1;
               st       <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wsq_checker.sv
module wsq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       bm_valid,
   input logic       bm_ready,
   input logic [1:0] bm_kind,
   input logic [7:0] bm_byte,
   input logic       bm_narrow,
   input logic       upd_done,
   input logic       upd_bad,
   input logic       upd_busy_rej,
   input logic       probe_done,
   input logic [1:0] ctl_kind
);
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (bm_valid && !bm_ready) |=> (bm_valid && $stable(bm_kind) && $stable(bm_byte))); // R11

   AST_NARROW_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bm_valid && bm_kind == 2'd1) |-> bm_narrow); // R8

   AST_WIDE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bm_valid && bm_kind == 2'd2) |-> !bm_narrow); // R8

   AST_DONE_AFTER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> (!bm_narrow && !$past(bm_narrow))); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |=> !upd_done); // R9

   AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      upd_bad |-> !bm_valid); // R5

   AST_REFUSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({upd_bad, upd_busy_rej})); // R10

   AST_PROBE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      probe_done |-> (ctl_kind != 2'd0 && !bm_valid)); // R3
endmodule

bind win_setup_seq wsq_checker i_wsq_checker (.*);

// File: tb/test_win_setup_seq.sv
module test_win_setup_seq;
   localparam int CLK_P = 10;
   localparam int CW    = 16;
   localparam int HR    = 800;
   localparam int VR    = 480;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          probe_go = 1'b0;
   logic          probe_done;
   logic [1:0]    ctl_kind;
   logic [1:0]    sil_rev;
   logic [2:0]    strap;
   logic          upd_req = 1'b0;
   logic [CW-1:0] upd_x = '0, upd_y = '0, upd_w = '0, upd_h = '0;
   logic          upd_bad, upd_busy_rej, upd_done;
   logic          bm_valid;
   logic          bm_ready;
   logic [1:0]    bm_kind;
   logic [7:0]    bm_byte;
   logic [7:0]    bm_rdata;
   logic          bm_narrow;

   win_setup_seq #(.COORD_W(CW), .H_RES(HR), .V_RES(VR)) i_win_setup_seq (
      .clk(clk), .rst_n(rst_n), .probe_go(probe_go), .probe_done(probe_done),
      .ctl_kind(ctl_kind), .sil_rev(sil_rev), .strap(strap),
      .upd_req(upd_req), .upd_x(upd_x), .upd_y(upd_y), .upd_w(upd_w), .upd_h(upd_h),
      .upd_bad(upd_bad), .upd_busy_rej(upd_busy_rej), .upd_done(upd_done),
      .bm_valid(bm_valid), .bm_ready(bm_ready), .bm_kind(bm_kind), .bm_byte(bm_byte),
      .bm_rdata(bm_rdata), .bm_narrow(bm_narrow)
   );

   always #(CLK_P/2) clk = ~clk;

   int         n_chk = 0;
   int         n_err = 0;
   bit         finished = 1'b0;
   logic [7:0] rev_val = 8'h00;
   logic [7:0] conf_val = 8'h00;
   logic [7:0] last_cmd = 8'h00;
   logic [7:0] lfsr = 8'h5B;
   int         nlog = 0;
   logic [1:0] lk [64];
   logic [7:0] lb [64];
   logic       ln [64];
   int         cur_kind = 0;

   // bus master model: ready pattern and transfer log, updated away from the edge
   initial begin
      bm_ready = 1'b0;
      bm_rdata = 8'h00;
      forever begin
         @(negedge clk);
         lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         bm_ready = lfsr[0] | lfsr[2];
         bm_rdata = (last_cmd == 8'h02) ? conf_val : rev_val;
         #1;
         if (bm_valid && bm_ready && nlog < 64) begin
            lk[nlog] = bm_kind;
            lb[nlog] = bm_byte;
            ln[nlog] = bm_narrow;
            nlog++;
            if (bm_kind == 2'd0) last_cmd = bm_byte;
         end
      end
   end

   task automatic check(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic tick;
      @(negedge clk);
      #2;
   endtask

   function automatic int exp_kind(input logic [7:0] rv);
      logic [7:0] m;
      m = rv & 8'hFC;
      if (m == 8'hA4) return 1;
      if (m == 8'h9C) return 2;
      return 3;
   endfunction

   function automatic int exp_burst(input int i, input int src);
      int g, v;
      if (i == 16) return 1;
      if (i == 17) return src;
      g = i % 8;
      case (g / 2)
         0: v = 0;
         1: v = 0;
         2: v = HR - 1;
         default: v = VR - 1;
      endcase
      return (g % 2 == 1) ? (v >> 8) & 255 : v & 255;
   endfunction

   task automatic wait_probe(output bit got);
      got = 1'b0;
      for (int k = 0; k < 300; k++) begin
         tick;
         if (probe_done) begin
            got = 1'b1;
            break;
         end
      end
   endtask

   task automatic probe(input logic [7:0] rv, input logic [7:0] cf);
      bit got;
      rev_val  = rv;
      conf_val = cf;
      nlog     = 0;
      probe_go = 1'b1;
      tick;
      probe_go = 1'b0;
      wait_probe(got);
      check("R2 probe_done seen", int'(got), 1);
      check("R2 transfer count", nlog, 4);
      check("R2 first command", {lk[0], lb[0]}, {2'd0, 8'h00});
      check("R2 first read kind", int'(lk[1]), 2);
      check("R2 second command", {lk[2], lb[2]}, {2'd0, 8'h02});
      check("R2 second read kind", int'(lk[3]), 2);
      check("R3 variant code", int'(ctl_kind), exp_kind(rv));
      check("R4 silicon revision", int'(sil_rev), int'(rv[1:0]));
      check("R4 strap bits", int'(strap), int'(cf[2:0]));
      cur_kind = exp_kind(rv);
      tick;
      check("R2 done is one cycle", int'(probe_done), 0);
   endtask

   task automatic wait_done(output bit got, output bit wide_before);
      logic prev;
      got = 1'b0;
      wide_before = 1'b0;
      prev = bm_narrow;
      for (int k = 0; k < 400; k++) begin
         tick;
         if (upd_done) begin
            got = 1'b1;
            wide_before = !prev;
            break;
         end
         prev = bm_narrow;
      end
   endtask

   task automatic check_burst;
      int src;
      src = (cur_kind == 1 || cur_kind == 2) ? 0 : 1;
      check("R6 transfer count", nlog, 19);
      check("R6 window command", {lk[0], lb[0]}, {2'd0, 8'h6C});
      check("R8 narrow at command", int'(ln[0]), 1);
      for (int i = 0; i < 18; i++) begin
         check("R6 data kind", int'(lk[i+1]), 1);
         check("R8 narrow during burst", int'(ln[i+1]), 1);
         if (i == 17) check("R7 source byte", int'(lb[i+1]), src);
         else         check("R6 burst byte", int'(lb[i+1]), exp_burst(i, src));
      end
   endtask

   task automatic do_update(input int x, input int y, input int w, input int h);
      bit ok, got, wb;
      ok = (x == 0 && y == 0 && w == HR && h == VR);
      nlog = 0;
      upd_x = CW'(x); upd_y = CW'(y); upd_w = CW'(w); upd_h = CW'(h);
      upd_req = 1'b1;
      tick;
      upd_req = 1'b0;
      check("R5 region refusal flag", int'(upd_bad), int'(!ok));
      check("R10 no busy refusal when idle", int'(upd_busy_rej), 0);
      if (ok) begin
         check("R8 narrow after accept", int'(bm_narrow), 1);
         wait_done(got, wb);
         check("R9 done seen", int'(got), 1);
         check("R9 bus wide at done", int'(bm_narrow), 0);
         check("R9 bus wide cycle before done", int'(wb), 1);
         check_burst;
         tick;
         check("R9 done one cycle", int'(upd_done), 0);
      end else begin
         tick; tick; tick;
         check("R5 no traffic on refusal", nlog, 0);
         check("R8 stays wide on refusal", int'(bm_narrow), 0);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      bit got, wb;
      tick; tick;
      check("R1 reset narrow", int'(bm_narrow), 0);
      check("R1 reset valid", int'(bm_valid), 0);
      check("R1 reset kind", int'(ctl_kind), 0);
      check("R1 reset pulses", int'({probe_done, upd_done, upd_bad, upd_busy_rej}), 0);
      rst_n = 1'b1;
      tick;
      check("R1 idle after release", int'(bm_valid), 0);

      // update before any probe: unknown variant selects 0x01 (R7)
      do_update(0, 0, HR, VR);

      // all identity values (R3, R4)
      for (int v = 0; v < 256; v++) probe(8'(v), 8'(v) ^ 8'h5A);

      probe(8'hA7, 8'h03);  do_update(0, 0, HR, VR);
      probe(8'h9D, 8'h06);  do_update(0, 0, HR, VR);
      probe(8'h00, 8'h07);  do_update(0, 0, HR, VR);
      probe(8'hA4, 8'h00);

      // region sweep (R5): exactly one point accepted
      for (int w = HR - 4; w <= HR + 4; w++)
         for (int h = VR - 4; h <= VR + 4; h++)
            do_update(0, 0, w, h);
      do_update(1, 0, HR, VR);
      do_update(0, 1, HR, VR);
      do_update(HR, VR, HR, VR);
      do_update(0, 0, 0, 0);

      // R10: request while a burst is running
      nlog = 0;
      upd_x = '0; upd_y = '0; upd_w = CW'(HR); upd_h = CW'(VR);
      upd_req = 1'b1;
      tick;
      upd_req = 1'b0;
      tick; tick;
      upd_req = 1'b1;
      tick;
      upd_req = 1'b0;
      check("R10 busy refusal during update", int'(upd_busy_rej), 1);
      check("R10 not a region refusal", int'(upd_bad), 0);
      wait_done(got, wb);
      check("R10 first update completes", int'(got), 1);
      repeat (8) tick;
      check("R10 no second burst", nlog, 19);

      // R10: request while a probe is running
      rev_val = 8'h9C; conf_val = 8'h01; nlog = 0;
      probe_go = 1'b1;
      tick;
      probe_go = 1'b0;
      upd_req = 1'b1;
      tick;
      upd_req = 1'b0;
      check("R10 busy refusal during probe", int'(upd_busy_rej), 1);
      wait_probe(got);
      repeat (6) tick;
      check("R10 probe traffic only", nlog, 4);
      check("R3 kind after probe with refused update", int'(ctl_kind), 2);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule